// File: doc/BRIEF.md
# Hold-Mode Slave Memory Port

This block gives an external bus master access to a small 16-bit-wide memory inside the chip. The access is possible only after the local processor has handed over the bus. While hold-acknowledge is low, the master drops chip-select and presents an address, a direction, two active-low byte-lane controls, a space selector and write data. The port performs one memory read or one memory write. It then pulls its active-low completion line low and keeps it low until the master releases chip-select.

The data and completion outputs are modelled as tristate pins. Each has a separate output-enable, and the enables follow the pin rules of the hold state. One further enable covers the port's own bus-master outputs: byte controls, status, direction, bus-start and burst. That enable is deasserted for the whole time the chip is in hold. Only user-space requests are served. A request marked for any other space gets no completion, and the master has to release chip-select before it can try again.

Top module: `hm_port`

## Requirements
- R1: A request is accepted only on a rising edge where `hold_ack_n` is low and `sel_n` is low. With `hold_ack_n` high, a low `sel_n` writes nothing and `done_n` stays high.
- R2: `rd_wr` high at acceptance makes the access a read. Low makes it a write.
- R3: In a write, `lane_n[1]` low writes bits 15:8 (the most significant byte) and `lane_n[0]` low writes bits 7:0. A lane whose control is high keeps its old contents. With both high, the location is unchanged.
- R4: A request with `space_n` high (not user space) writes nothing and never pulls `done_n` low. The port then ignores the bus until `sel_n` has been seen high.
- R5: If a request is accepted at edge T, the memory operation takes effect at edge T+1 and `done_n` falls at edge T+2. `done_n` stays low while `sel_n` stays low.
- R6: `done_n` returns high on the edge after `sel_n` is sampled high. While `done_n` is low, changes on the other inputs start no second access.
- R7: `rdata_oe` is high exactly when `hold_ack_n` is low, `sel_n` is low and `rd_wr` is high, with no clock delay.
- R8: `done_oe` is high exactly when `hold_ack_n` is low and `sel_n` is low, with no clock delay.
- R9: `master_ctl_oe` is low whenever `hold_ack_n` is low, and high otherwise.
- R10: After reset, `done_n` is high and `rdata` is zero.
- R11: A read loads `rdata` with the addressed word at edge T+1. `rdata` keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_ack_n | input | 1 | Low while the bus is granted to the external master |
| sel_n | input | 1 | Active-low chip-select from the external master |
| space_n | input | 1 | Low selects user space |
| rd_wr | input | 1 | High for read, low for write |
| lane_n | input | LANES (2) | Active-low byte-lane write controls, bit 1 is the upper byte |
| addr | input | AW (8) | Word address |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data, valid while rdata_oe is high |
| rdata_oe | output | 1 | Drive enable for the data pins |
| done_n | output | 1 | Active-low completion |
| done_oe | output | 1 | Drive enable for the completion pin |
| master_ctl_oe | output | 1 | Drive enable for the port's own bus-master outputs |

## Verification
A stuck or skipped state in the request sequencer shows up at the ports as a change in `done_n` timing. Completion arrives a cycle early or late. It may never arrive, or it may survive the release of chip-select. Each of these is seen within three clocks of the stimulus. A lost byte-lane enable or a stale capture register leaves the memory wrong without any immediate sign, so the bench reads each written location back and compares it against its own memory image. Enable errors are combinational and are visible in the same cycle.

// File: rtl/hm_pkg.sv
package hm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_XFER   = 3'd1,
      ST_SETTLE = 3'd2,
      ST_DONE   = 3'd3,
      ST_LOCK   = 3'd4
   } hm_state_t;
endpackage

// File: rtl/hm_lane_ram.sv
module hm_lane_ram #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] we,
   input  logic             re,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   // One independent bank per byte lane; a lane only ever sees its own enable.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] rq;

      always_ff @(posedge clk) begin
         if (we[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rq <= '0;
         else if (re) rq <= bank[addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = rq;
   end
endmodule

// File: rtl/hm_req_ctl.sv
module hm_req_ctl
   import hm_pkg::*;
#(
   parameter int AW     = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_ack_n,
   input  logic             sel_n,
   input  logic             space_n,
   input  logic             rd_wr,
   input  logic [LANES-1:0] lane_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [LANES-1:0] mem_we,
   output logic             mem_re,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   output logic             done_n
);
   hm_state_t        state;
   logic             cap_rd;
   logic [LANES-1:0] cap_lane_n;
   logic [AW-1:0]    cap_addr;
   logic [DW-1:0]    cap_wdata;
   logic             granted;

   assign granted = !hold_ack_n && !sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cap_rd     <= 1'b1;
         cap_lane_n <= '1;
         cap_addr   <= '0;
         cap_wdata  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (granted) begin
                  if (!space_n) begin
                     state      <= ST_XFER;
                     cap_rd     <= rd_wr;
                     cap_lane_n <= lane_n;
                     cap_addr   <= addr;
                     cap_wdata  <= wdata;
                  end else begin
                     state <= ST_LOCK;
                  end
               end
            end
            ST_XFER:   state <= ST_SETTLE;
            ST_SETTLE: state <= ST_DONE;
            ST_DONE,
            ST_LOCK:   if (sel_n) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_re    = (state == ST_XFER) && cap_rd;
      mem_we    = ((state == ST_XFER) && !cap_rd) ? ~cap_lane_n : '0;
      mem_addr  = cap_addr;
      mem_wdata = cap_wdata;
      done_n    = (state != ST_DONE);
   end
endmodule

// File: rtl/hm_pin_ctl.sv
module hm_pin_ctl (
   input  logic hold_ack_n,
   input  logic sel_n,
   input  logic rd_wr,
   output logic rdata_oe,
   output logic done_oe,
   output logic master_ctl_oe
);
   logic in_hold;
   assign in_hold       = !hold_ack_n;
   assign done_oe       = in_hold && !sel_n;
   assign rdata_oe      = in_hold && !sel_n && rd_wr;
   assign master_ctl_oe = !in_hold;
endmodule

// File: rtl/hm_port.sv
module hm_port #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_ack_n,
   input  logic             sel_n,
   input  logic             space_n,
   input  logic             rd_wr,
   input  logic [LANES-1:0] lane_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe,
   output logic             done_n,
   output logic             done_oe,
   output logic             master_ctl_oe
);
   if (DEPTH < 2)           begin : g_bad_depth  $error("DEPTH must be at least 2");  end
   if ((1 << AW) != DEPTH)  begin : g_bad_pow2   $error("DEPTH must be a power of two"); end
   if (LANES < 1)           begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (LANE_W < 1)          begin : g_bad_lanew  $error("LANE_W must be at least 1"); end

   logic [LANES-1:0] mem_we;
   logic             mem_re;
   logic [AW-1:0]    mem_addr;
   logic [DW-1:0]    mem_wdata;

   hm_req_ctl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .hold_ack_n(hold_ack_n), .sel_n(sel_n),
      .space_n(space_n), .rd_wr(rd_wr), .lane_n(lane_n), .addr(addr),
      .wdata(wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .done_n(done_n)
   );

   hm_lane_ram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re), .addr(mem_addr),
      .wdata(mem_wdata), .rdata(rdata)
   );

   hm_pin_ctl u_pins (
      .hold_ack_n(hold_ack_n), .sel_n(sel_n), .rd_wr(rd_wr),
      .rdata_oe(rdata_oe), .done_oe(done_oe), .master_ctl_oe(master_ctl_oe)
   );
endmodule

// File: rtl/hm_port_chk.sv
module hm_port_chk (
   input logic clk,
   input logic rst_n,
   input logic hold_ack_n,
   input logic sel_n,
   input logic space_n,
   input logic rd_wr,
   input logic done_n,
   input logic done_oe,
   input logic rdata_oe,
   input logic master_ctl_oe
);
   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_n) |-> $past(!hold_ack_n && !sel_n && !space_n, 2));

   p_data_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (rd_wr && !sel_n));

   p_done_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_oe |-> (!sel_n && !hold_ack_n));

   p_ctl_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_ack_n |-> !master_ctl_oe);

   p_done_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_n && !sel_n) |=> !done_n);

   p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_n && sel_n) |=> done_n);
endmodule

bind hm_port hm_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hold_ack_n(hold_ack_n), .sel_n(sel_n),
   .space_n(space_n), .rd_wr(rd_wr), .done_n(done_n), .done_oe(done_oe),
   .rdata_oe(rdata_oe), .master_ctl_oe(master_ctl_oe)
);

// File: tb/hm_port_test.sv
`timescale 1ns/1ps
module hm_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_ack_n = 1'b1;
   logic        sel_n = 1'b1;
   logic        space_n = 1'b0;
   logic        rd_wr = 1'b1;
   logic [1:0]  lane_n = 2'b11;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rdata_oe, done_n, done_oe, master_ctl_oe;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   hm_port uut (
      .clk(clk), .rst_n(rst_n), .hold_ack_n(hold_ack_n), .sel_n(sel_n),
      .space_n(space_n), .rd_wr(rd_wr), .lane_n(lane_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .done_n(done_n),
      .done_oe(done_oe), .master_ctl_oe(master_ctl_oe)
   );

   // Behavioural reference: phase 0 idle, 1 op pending, 2 settle, 3 done, 4 locked out
   int          m_phase = 0;
   logic [15:0] m_mem [int];
   logic [15:0] m_rd = '0;
   logic        c_rd;
   logic [1:0]  c_ln;
   logic [7:0]  c_a;
   logic [15:0] c_d;
   logic [15:0] img [int];   // scoreboard image from the requirements

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0;
         m_rd    = '0;
      end else begin
         if (m_phase == 0) begin
            if (!hold_ack_n && !sel_n) begin
               if (!space_n) begin
                  c_rd = rd_wr; c_ln = lane_n; c_a = addr; c_d = wdata;
                  m_phase = 1;
               end else m_phase = 4;
            end
         end else if (m_phase == 1) begin
            if (c_rd) m_rd = m_mem.exists(c_a) ? m_mem[c_a] : 16'h0;
            else begin
               logic [15:0] w;
               w = m_mem.exists(c_a) ? m_mem[c_a] : 16'h0;
               if (!c_ln[1]) w[15:8] = c_d[15:8];
               if (!c_ln[0]) w[7:0]  = c_d[7:0];
               m_mem[c_a] = w;
            end
            m_phase = 2;
         end else if (m_phase == 2) m_phase = 3;
         else if (sel_n) m_phase = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // compare against the model on every clock, 1 ns after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk("R5 done_n vs model", {31'b0, done_n}, {31'b0, m_phase != 3});
         chk("R7 rdata_oe", {31'b0, rdata_oe}, {31'b0, !hold_ack_n && !sel_n && rd_wr});
         chk("R8 done_oe", {31'b0, done_oe}, {31'b0, !hold_ack_n && !sel_n});
         chk("R9 master_ctl_oe", {31'b0, master_ctl_oe}, {31'b0, hold_ack_n});
         chk("R11 rdata vs model", {16'b0, rdata}, {16'b0, m_rd});
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic access(input logic rd, input logic [7:0] a, input logic [1:0] ln,
                         input logic [15:0] d, input logic sp, output int lat);
      @(negedge clk);
      addr = a; rd_wr = rd; lane_n = ln; wdata = d; space_n = sp; sel_n = 1'b0;
      lat = 0;
      while (done_n === 1'b1 && lat < 8) begin
         @(negedge clk);
         lat++;
      end
      @(negedge clk);
      sel_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] ln, input logic [15:0] d);
      int lat;
      logic [15:0] w;
      access(1'b0, a, ln, d, 1'b0, lat);
      chk("R5 write completion latency", lat, 3);
      w = img.exists(a) ? img[a] : 16'h0;
      if (!ln[1]) w[15:8] = d[15:8];
      if (!ln[0]) w[7:0]  = d[7:0];
      img[a] = w;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a);
      int lat;
      access(1'b1, a, 2'b00, 16'hFFFF, 1'b0, lat);
      chk("R5 read completion latency", lat, 3);
      chk(req, {16'b0, rdata}, {16'b0, img[a]});
   endtask

   initial begin
      int lat;
      #1;
      chk("R10 reset done_n", {31'b0, done_n}, 32'd1);
      chk("R10 reset rdata", {16'b0, rdata}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 done_n after reset", {31'b0, done_n}, 32'd1);
      hold_ack_n = 1'b0;

      // R2 R11: full writes and read-back
      wr(8'h03, 2'b00, 16'hA5C3);
      wr(8'hFF, 2'b00, 16'h1234);
      wr(8'h00, 2'b00, 16'h8001);
      rd_chk("R2 R11 read addr 03", 8'h03);
      rd_chk("R2 R11 read addr FF", 8'hFF);
      rd_chk("R2 R11 read addr 00", 8'h00);

      // R3: lane writes
      wr(8'h03, 2'b01, 16'h77EE);   // upper only
      rd_chk("R3 upper lane only", 8'h03);
      chk("R3 upper lane value", {16'b0, rdata}, 32'h77C3);
      wr(8'h03, 2'b10, 16'h1199);   // lower only
      rd_chk("R3 lower lane only", 8'h03);
      wr(8'h03, 2'b11, 16'h0000);   // no lanes
      rd_chk("R3 no lane leaves word", 8'h03);
      chk("R3 word unchanged", {16'b0, rdata}, 32'h7799);

      // R4: non-user space is ignored
      access(1'b0, 8'h03, 2'b00, 16'hDEAD, 1'b1, lat);
      chk("R4 no completion for space high", lat, 8);
      rd_chk("R4 memory untouched", 8'h03);

      // R1: no acceptance outside hold
      @(negedge clk);
      hold_ack_n = 1'b1;
      addr = 8'hFF; rd_wr = 1'b0; lane_n = 2'b00; wdata = 16'hBEEF; space_n = 1'b0;
      sel_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1 no completion outside hold", {31'b0, done_n}, 32'd1);
      chk("R9 ctl enable outside hold", {31'b0, master_ctl_oe}, 32'd1);
      sel_n = 1'b1;
      @(negedge clk);
      hold_ack_n = 1'b0;
      rd_chk("R1 memory untouched outside hold", 8'hFF);

      // R6: done held while sel low, no second access
      @(negedge clk);
      addr = 8'h10; rd_wr = 1'b0; lane_n = 2'b00; wdata = 16'h4242; space_n = 1'b0;
      sel_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 done low at T+2", {31'b0, done_n}, 32'd0);
      wdata = 16'h9999; addr = 8'h11;
      repeat (4) @(negedge clk);
      chk("R6 done stays low while selected", {31'b0, done_n}, 32'd0);
      sel_n = 1'b1;
      @(negedge clk);
      chk("R6 done released after deselect", {31'b0, done_n}, 32'd1);
      img[8'h10] = 16'h4242;
      img[8'h11] = 16'h0000;
      rd_chk("R6 single write only", 8'h10);
      wr(8'h11, 2'b00, 16'h5A5A);
      rd_chk("R6 second location after fresh select", 8'h11);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule